// File: doc/BRIEF.md
# Banked GPIO Controller with Write-One Set and Clear

This block is a memory-mapped general-purpose I/O controller. It drives and samples a row of pins arranged as banks of 32 pins, five banks by default. A simple single-cycle register bus reaches it: a write is taken on the clock edge where select and write are both high, and read data is combinational from the address. Each bank can make every pin an input or an output. A bank can set or clear any group of output bits in one write, without reading the latch first. It reads back the pin levels through a two-stage synchronizer. It also raises an interrupt on enabled rising or falling pin edges.

The pad side gets the output latch, an output enable per pin and one interrupt line. The interrupt line is the OR of all bank status bits. Pin multiplexing, pad electrical behaviour, clock gating and any bus bridge sit outside this block.

Top module: `pinbank_gpio`

## Requirements
- R1: After reset, every pin is an input (pin_oe all 0) and pin_out is all 0. The direction register of every bank reads all ones, and the output, edge-enable and status registers read 0. irq is 0.
- R2: The direction register is at bank offset 0x00. A bit of 1 makes the pin an input and a bit of 0 makes it an output, so pin_oe for the pin is the inverse of its direction bit. A write replaces the register and a read returns it.
- R3: The set register is at bank offset 0x08. Each 1 written drives that output latch bit high, and each 0 leaves the bit unchanged. A read returns the output latch.
- R4: The clear register is at bank offset 0x0C. Each 1 written drives that output latch bit low, and each 0 leaves the bit unchanged. A read returns the output latch.
- R5: The output data register is at bank offset 0x04. A write replaces the whole latch, and a read returns it. pin_out and pin_oe change only after a bus write.
- R6: Bank b starts at byte address 0x10 + 0x28*b. Bit i of every register in bank b belongs to pin 32*b + i.
- R7: The input data register is at bank offset 0x10. It returns the pin levels after two clock stages: a level driven before one edge reads back only after the second edge. The register shows the level of output pins too, and writes to it have no effect.
- R8: Rising-edge enables are set by writing ones at offset 0x14 and cleared by writing ones at offset 0x18. Falling-edge enables use offsets 0x1C (set) and 0x20 (clear). A read at either address of a pair returns that enable mask.
- R9: The status register is at offset 0x24. An enabled edge sets its bit one clock after it reaches the input register, and an edge that is not enabled sets nothing. Writing a 1 to a status bit clears it. When a new edge and a clear of the same bit happen in the same cycle, the bit stays set.
- R10: irq is 1 exactly when any status bit of any bank is 1.
- R11: Addresses outside the bank blocks, and addresses whose low two bits are not 0, read as 0. Writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W (8) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the address |
| pin_in | input | NUM_BANKS*32 (160) | Pin levels from the pads |
| pin_out | output | NUM_BANKS*32 (160) | Output latch to the pads |
| pin_oe | output | NUM_BANKS*32 (160) | Output enable per pin |
| irq | output | 1 | Combined edge interrupt |

## Verification
The bench writes a different direction and data pattern into each bank and compares the whole pin_out and pin_oe vectors after every write. A write that lands in the wrong bank or the wrong bit therefore shows up. Set and clear masks overlap bits that are already 1 and bits that are 0, which separates write-one from plain replace. The input register is read one cycle and two cycles after a pin change, which fixes the synchronizer depth. The edge tests drive enabled and disabled rising and falling edges, and one case lines up a clear with a fresh edge in the same cycle.

// File: rtl/pinbank_gpio_pkg.sv
package pinbank_gpio_pkg;

    // Word index of a register inside a bank (byte offset / 4).
    typedef enum logic [3:0] {
        RG_DIR      = 4'd0,
        RG_DOUT     = 4'd1,
        RG_DSET     = 4'd2,
        RG_DCLR     = 4'd3,
        RG_DIN      = 4'd4,
        RG_RISE_SET = 4'd5,
        RG_RISE_CLR = 4'd6,
        RG_FALL_SET = 4'd7,
        RG_FALL_CLR = 4'd8,
        RG_STAT     = 4'd9
    } gpio_reg_e;

    localparam int REGS_PER_BANK = 10;

endpackage

// File: rtl/pinbank_gpio_dec.sv
module pinbank_gpio_dec
    import pinbank_gpio_pkg::*;
#(
    parameter int NUM_BANKS = 5,
    parameter int ADDR_W    = 8,
    parameter int BASE_OFF  = 16,
    parameter int STRIDE    = 40,
    localparam int BW       = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [BW-1:0]     bank,
    output gpio_reg_e         regi
);

    logic [31:0] addr32;
    logic [31:0] lo32;
    logic [31:0] off32;

    always_comb begin
        hit    = 1'b0;
        bank   = '0;
        regi   = RG_DIR;
        addr32 = 32'(addr);
        lo32   = '0;
        off32  = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            lo32  = 32'(BASE_OFF) + 32'(b) * 32'(STRIDE);
            off32 = addr32 - lo32;
            if ((addr32 >= lo32) && (addr32 < lo32 + 32'(STRIDE)) && (addr[1:0] == 2'b00)) begin
                hit  = 1'b1;
                bank = BW'(b);
                regi = gpio_reg_e'(off32[5:2]);
            end
        end
    end

endmodule

// File: rtl/pinbank_gpio_sync.sv
module pinbank_gpio_sync #(
    parameter int W = 160
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pins,
    output logic [W-1:0] level,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] s3;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d.s1 = pins;
        sync_d.s2 = sync_q.s1;
        sync_d.s3 = sync_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign level = sync_q.s2;
    assign rise  = sync_q.s2 & ~sync_q.s3;
    assign fall  = ~sync_q.s2 & sync_q.s3;

endmodule

// File: rtl/pinbank_gpio_bank.sv
module pinbank_gpio_bank
    import pinbank_gpio_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  gpio_reg_e    regi,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] level,
    input  logic [W-1:0] rise,
    input  logic [W-1:0] fall,
    output logic [W-1:0] rdata,
    output logic [W-1:0] dout,
    output logic [W-1:0] oe,
    output logic         any_stat
);

    typedef struct packed {
        logic [W-1:0] dir;
        logic [W-1:0] dout;
        logic [W-1:0] ren;
        logic [W-1:0] fen;
        logic [W-1:0] stat;
    } bank_t;

    bank_t st_d, st_q;
    logic [W-1:0] stat_clr;

    always_comb begin
        st_d     = st_q;
        stat_clr = '0;
        if (wr_en) begin
            unique case (regi)
                RG_DIR:      st_d.dir  = wdata;
                RG_DOUT:     st_d.dout = wdata;
                RG_DSET:     st_d.dout = st_q.dout | wdata;
                RG_DCLR:     st_d.dout = st_q.dout & ~wdata;
                RG_RISE_SET: st_d.ren  = st_q.ren | wdata;
                RG_RISE_CLR: st_d.ren  = st_q.ren & ~wdata;
                RG_FALL_SET: st_d.fen  = st_q.fen | wdata;
                RG_FALL_CLR: st_d.fen  = st_q.fen & ~wdata;
                RG_STAT:     stat_clr  = wdata;
                default:     ;
            endcase
        end
        // A fresh enabled edge wins over a clear of the same bit.
        st_d.stat = (st_q.stat & ~stat_clr) | (rise & st_q.ren) | (fall & st_q.fen);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.dir  <= '1;
            st_q.dout <= '0;
            st_q.ren  <= '0;
            st_q.fen  <= '0;
            st_q.stat <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        unique case (regi)
            RG_DIR:                   rdata = st_q.dir;
            RG_DOUT, RG_DSET, RG_DCLR: rdata = st_q.dout;
            RG_DIN:                   rdata = level;
            RG_RISE_SET, RG_RISE_CLR: rdata = st_q.ren;
            RG_FALL_SET, RG_FALL_CLR: rdata = st_q.fen;
            RG_STAT:                  rdata = st_q.stat;
            default:                  rdata = '0;
        endcase
    end

    assign dout     = st_q.dout;
    assign oe       = ~st_q.dir;
    assign any_stat = |st_q.stat;

endmodule

// File: rtl/pinbank_gpio.sv
module pinbank_gpio
    import pinbank_gpio_pkg::*;
#(
    parameter int NUM_BANKS = 5,
    parameter int BANK_W    = 32,
    parameter int ADDR_W    = 8,
    parameter int BASE_OFF  = 16,
    parameter int STRIDE    = 40,
    localparam int NPINS    = NUM_BANKS * BANK_W,
    localparam int BW       = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BANK_W-1:0] bus_wdata,
    output logic [BANK_W-1:0] bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic              irq
);

    logic            dec_hit;
    logic [BW-1:0]   dec_bank;
    gpio_reg_e       dec_reg;

    logic [NPINS-1:0]  lvl, rise, fall;
    logic [BANK_W-1:0] bank_rd [NUM_BANKS];
    logic [NUM_BANKS-1:0] bank_irq;

    pinbank_gpio_dec #(
        .NUM_BANKS (NUM_BANKS),
        .ADDR_W    (ADDR_W),
        .BASE_OFF  (BASE_OFF),
        .STRIDE    (STRIDE)
    ) u_dec (
        .addr (bus_addr),
        .hit  (dec_hit),
        .bank (dec_bank),
        .regi (dec_reg)
    );

    pinbank_gpio_sync #(.W(NPINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pins  (pin_in),
        .level (lvl),
        .rise  (rise),
        .fall  (fall)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic wr_this;
        assign wr_this = bus_sel && bus_wr && dec_hit && (dec_bank == BW'(b));

        pinbank_gpio_bank #(.W(BANK_W)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_this),
            .regi     (dec_reg),
            .wdata    (bus_wdata),
            .level    (lvl[b*BANK_W +: BANK_W]),
            .rise     (rise[b*BANK_W +: BANK_W]),
            .fall     (fall[b*BANK_W +: BANK_W]),
            .rdata    (bank_rd[b]),
            .dout     (pin_out[b*BANK_W +: BANK_W]),
            .oe       (pin_oe[b*BANK_W +: BANK_W]),
            .any_stat (bank_irq[b])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bus_sel && dec_hit && (dec_bank == BW'(b))) bus_rdata = bank_rd[b];
        end
    end

    assign irq = |bank_irq;

endmodule

// File: rtl/pinbank_gpio_chk.sv
module pinbank_gpio_chk #(
    parameter int NUM_BANKS = 5,
    parameter int BANK_W    = 32,
    parameter int ADDR_W    = 8,
    parameter int BASE_OFF  = 16,
    localparam int NPINS    = NUM_BANKS * BANK_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [BANK_W-1:0] bus_wdata,
    input logic [NPINS-1:0]  pin_out,
    input logic [NPINS-1:0]  pin_oe
);

    localparam logic [ADDR_W-1:0] A_DIR0 = ADDR_W'(BASE_OFF);
    localparam logic [ADDR_W-1:0] A_SET0 = ADDR_W'(BASE_OFF + 8);
    localparam logic [ADDR_W-1:0] A_CLR0 = ADDR_W'(BASE_OFF + 12);

    logic wr_any;
    assign wr_any = bus_sel && bus_wr;

    // R2: direction write to bank 0 sets the enables of pins 0..31 to its inverse
    p_dir_oe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && bus_addr == A_DIR0) |=> (pin_oe[BANK_W-1:0] == ~$past(bus_wdata)));

    // R3: every written one of the set register appears high on the pads
    p_set_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && bus_addr == A_SET0) |=>
            ((pin_out[BANK_W-1:0] & $past(bus_wdata)) == $past(bus_wdata)));

    // R4: every written one of the clear register appears low on the pads
    p_clr_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && bus_addr == A_CLR0) |=> ((pin_out[BANK_W-1:0] & $past(bus_wdata)) == '0));

    // R5: pads hold still in cycles with no bus write
    p_pad_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_any |=> ($stable(pin_out) && $stable(pin_oe)));

endmodule

bind pinbank_gpio pinbank_gpio_chk #(
    .NUM_BANKS (NUM_BANKS),
    .BANK_W    (BANK_W),
    .ADDR_W    (ADDR_W),
    .BASE_OFF  (BASE_OFF)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
);

// File: tb/pinbank_gpio_bench.sv
`timescale 1ns/1ps
module pinbank_gpio_bench;

    localparam int NB = 5;
    localparam int W  = 32;
    localparam int NP = NB * W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [W-1:0]  bus_wdata = '0;
    logic [W-1:0]  bus_rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out;
    logic [NP-1:0] pin_oe;
    logic          irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [W-1:0] m_dir [NB];
    logic [W-1:0] m_out [NB];

    always #4 clk = ~clk;

    pinbank_gpio u_pinbank_gpio (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    function automatic logic [7:0] ra(int b, int r);
        return 8'(16 + 40 * b + 4 * r);
    endfunction

    function automatic logic [NP-1:0] exp_oe();
        logic [NP-1:0] v;
        for (int b = 0; b < NB; b++) v[b*W +: W] = ~m_dir[b];
        return v;
    endfunction

    function automatic logic [NP-1:0] exp_out();
        logic [NP-1:0] v;
        for (int b = 0; b < NB; b++) v[b*W +: W] = m_out[b];
        return v;
    endfunction

    task automatic check(string req, string what, logic [NP-1:0] got, logic [NP-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [W-1:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [W-1:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic pads(string req, string what);
        check(req, {what, " oe"}, pin_oe, exp_oe());
        check(req, {what, " out"}, pin_out, exp_out());
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] d;
        logic [W-1:0] pat;
        for (int b = 0; b < NB; b++) begin m_dir[b] = '1; m_out[b] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state at the ports and in every register
        pads("R1", "reset");
        check("R1", "irq reset", NP'(irq), '0);
        for (int b = 0; b < NB; b++) begin
            rd(ra(b, 0), d); check("R1", "dir reset", NP'(d), NP'(32'hFFFF_FFFF));
            for (int r = 1; r < 10; r++) begin
                if (r != 4) begin rd(ra(b, r), d); check("R1", "reg reset", NP'(d), '0); end
            end
        end

        // R2 R6: direction pattern per bank, whole pad vector compared
        for (int b = 0; b < NB; b++) begin
            pat = 32'h0F0F_A5A5 ^ (32'h1111_1111 * 32'(b));
            wr(ra(b, 0), pat); m_dir[b] = pat;
            pads("R2", "dir write");
            rd(ra(b, 0), d); check("R6", "dir readback", NP'(d), NP'(pat));
        end

        // R5 R6: whole-latch replace per bank
        for (int b = 0; b < NB; b++) begin
            pat = 32'hC3C3_3C3C + 32'h0101_0101 * 32'(b);
            wr(ra(b, 1), pat); m_out[b] = pat;
            pads("R5", "dout write");
            rd(ra(b, 1), d); check("R5", "dout readback", NP'(d), NP'(pat));
        end

        // R3: set with overlapping masks; read through set address
        for (int b = 0; b < NB; b++) begin
            pat = 32'h0000_FFFF << (4 * b);
            wr(ra(b, 2), pat); m_out[b] |= pat;
            pads("R3", "set");
            rd(ra(b, 2), d); check("R3", "set addr read", NP'(d), NP'(m_out[b]));
        end

        // R4: clear with overlapping masks; read through clear address
        for (int b = 0; b < NB; b++) begin
            pat = 32'hF0F0_F0F0 >> b;
            wr(ra(b, 3), pat); m_out[b] &= ~pat;
            pads("R4", "clear");
            rd(ra(b, 3), d); check("R4", "clear addr read", NP'(d), NP'(m_out[b]));
        end

        // R7: two-stage lag, then levels per bank
        @(negedge clk);
        pin_in[31:0] = 32'hDEAD_BEEF;
        rd(ra(0, 4), d); check("R7", "in after 1 edge", NP'(d), '0);
        rd(ra(0, 4), d); check("R7", "in after 2 edges", NP'(d), NP'(32'hDEAD_BEEF));
        @(negedge clk);
        for (int b = 1; b < NB; b++) pin_in[b*W +: W] = 32'h1234_5678 * 32'(b + 1);
        repeat (3) @(negedge clk);
        for (int b = 0; b < NB; b++) begin
            rd(ra(b, 4), d); check("R7", "in level", NP'(d), NP'(pin_in[b*W +: W]));
        end
        wr(ra(3, 4), 32'hFFFF_FFFF);
        pads("R7", "in write");
        rd(ra(3, 4), d); check("R7", "in after write", NP'(d), NP'(pin_in[3*W +: W]));

        // restore pins low and let the pipeline settle before edge tests
        @(negedge clk) pin_in = '0;
        repeat (4) @(negedge clk);

        // R8: enable set/clear pairs
        wr(ra(2, 5), 32'h00FF_00FF);
        wr(ra(2, 5), 32'h0F00_0000);
        rd(ra(2, 6), d); check("R8", "rise mask", NP'(d), NP'(32'h0FFF_00FF));
        wr(ra(2, 6), 32'h0000_00F0);
        rd(ra(2, 5), d); check("R8", "rise after clr", NP'(d), NP'(32'h0FFF_000F));
        wr(ra(2, 7), 32'h1234_5678);
        rd(ra(2, 8), d); check("R8", "fall mask", NP'(d), NP'(32'h1234_5678));
        rd(ra(2, 6), d); check("R8", "rise untouched", NP'(d), NP'(32'h0FFF_000F));
        wr(ra(2, 6), 32'hFFFF_FFFF);
        wr(ra(2, 8), 32'hFFFF_FFFF);

        // R9 R10: rising edge enabled on pin 35 (bank 1 bit 3)
        wr(ra(1, 5), 32'h0000_0008);
        @(negedge clk) pin_in[35] = 1'b1;
        repeat (4) @(negedge clk);
        rd(ra(1, 9), d); check("R9", "rise status", NP'(d), NP'(32'h8));
        check("R10", "irq set", NP'(irq), NP'(1));
        @(negedge clk) pin_in[35] = 1'b0;
        repeat (4) @(negedge clk);
        rd(ra(1, 9), d); check("R9", "fall not enabled", NP'(d), NP'(32'h8));
        wr(ra(1, 9), 32'h0000_0008);
        rd(ra(1, 9), d); check("R9", "status cleared", NP'(d), '0);
        check("R10", "irq clear", NP'(irq), '0);

        // R9: edge and clear of the same bit in the same cycle
        @(negedge clk) pin_in[35] = 1'b1;
        @(negedge clk);
        wr(ra(1, 9), 32'h0000_0008);
        rd(ra(1, 9), d); check("R9", "edge beats clear", NP'(d), NP'(32'h8));
        wr(ra(1, 9), 32'h0000_0008);

        // R9 R10: falling enable on pin 159 (bank 4 bit 31)
        wr(ra(4, 7), 32'h8000_0000);
        @(negedge clk) pin_in[159] = 1'b1;
        repeat (4) @(negedge clk);
        rd(ra(4, 9), d); check("R9", "rise not enabled", NP'(d), '0);
        check("R10", "irq idle", NP'(irq), '0);
        @(negedge clk) pin_in[159] = 1'b0;
        repeat (4) @(negedge clk);
        rd(ra(4, 9), d); check("R9", "fall status", NP'(d), NP'(32'h8000_0000));
        check("R10", "irq from bank 4", NP'(irq), NP'(1));
        wr(ra(4, 9), 32'hFFFF_FFFF);
        check("R10", "irq after clear", NP'(irq), '0);

        // R11: holes, gap before bank 0, past last bank, unaligned
        rd(8'h00, d); check("R11", "below base", NP'(d), '0);
        rd(8'hD8, d); check("R11", "past end", NP'(d), '0);
        rd(8'h11, d); check("R11", "unaligned", NP'(d), '0);
        wr(8'h04, 32'hFFFF_FFFF);
        wr(8'hD8, 32'hFFFF_FFFF);
        wr(8'h12, 32'h0000_0000);
        pads("R11", "unmapped writes");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule